// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in in pure combinational logic. It contains no state, so the result appears in the same cycle as the operands. The operand width is split into four 4-bit slices. Each slice forms a generate term (both bits set) and a propagate term (bits differ) for every bit position. From these it computes its carries in flat sum-of-products form, so that no carry waits on a neighbouring carry. Each slice also reports one group generate and one group propagate.

A second lookahead stage uses the same expansion on the four group terms and the external carry-in. It produces the carry into slices 1 to 3 and the final carry-out, and its own group terms are brought out. A third-level stage can therefore join several of these adders into a wider word without rippling between them. The house state-machine style does not apply here: the block has no states, no clock and no reset, so only its naming and layout conventions are kept.

Top module: `cla2_adder`

## Requirements
- R1: For every input combination, the 17-bit value {c_out, sum_out} equals a_in + b_in + c_in.
- R2: With a_in = 16'hFFFF, b_in = 16'h0000 and c_in = 1, the carry crosses all 16 positions: sum_out = 16'h0000 and c_out = 1.
- R3: grp_p is 1 exactly when every bit pair differs, that is when (a_in XOR b_in) = 16'hFFFF. This holds whatever the value of c_in.
- R4: grp_g is 1 exactly when a_in + b_in, taken without c_in, is 2^16 or more.
- R5: c_out always equals grp_g OR (grp_p AND c_in). Inside each slice, the carry out of the top bit equals the slice's group generate OR (its group propagate AND its carry-in).
- R6: The carry into slice k (bit 4k, k = 1..3) equals bit 4k of the sum of the low 4k bits of both operands plus c_in. Every carry obeys next = generate OR (propagate AND previous).
- R7: grp_g and grp_p are never both 1. The same holds for each slice's group pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| grp_p | output | 1 | Whole-word group propagate |
| grp_g | output | 1 | Whole-word group generate |

## Verification
The in-line checks assume that a slice's generate and propagate bits come from the same operand pair. This is why the group exclusion (R7) is asserted only inside the slices and not in the lookahead stage, whose inputs could in principle be arbitrary. The stimulus holds every operand steady from one falling clock edge to the next, so the immediate checks only see settled values. Directed vectors target full carry chains, carries that stop at a slice boundary and the both-operands-saturated case. A random sweep covers the remaining input space.

// File: rtl/cla2_pkg.sv
package cla2_pkg;
    localparam int SLICE_W    = 4;
    localparam int NUM_SLICES = 4;
    localparam int SUM_W      = SLICE_W * NUM_SLICES;
endpackage

// File: rtl/cla2_slice.sv
module cla2_slice #(
    parameter int W = cla2_pkg::SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c0,
    output logic [W-1:0] s,
    output logic         gg,
    output logic         gp
);
    logic [W-1:0] g_bit;
    logic [W-1:0] p_bit;
    logic [W:0]   cy;
    logic         acc;
    logic         term;
    logic         grp_gen;
    logic         grp_prop;

    always_comb begin
        g_bit = a & b;
        p_bit = a ^ b;
        cy    = '0;
        cy[0] = c0;
        // each carry expanded in two levels from g, p and c0 only
        for (int k = 1; k <= W; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = g_bit[j];
                for (int m = j + 1; m < k; m++) term = term & p_bit[m];
                acc = acc | term;
            end
            term = c0;
            for (int m = 0; m < k; m++) term = term & p_bit[m];
            cy[k] = acc | term;
        end
        grp_gen = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = g_bit[j];
            for (int m = j + 1; m < W; m++) term = term & p_bit[m];
            grp_gen = grp_gen | term;
        end
        grp_prop = &p_bit;

        for (int k = 0; k < W; k++) begin
            assert_carry_step_R6: assert (cy[k+1] == (g_bit[k] | (p_bit[k] & cy[k])));
        end
        assert_slice_group_R5: assert (cy[W] == (grp_gen | (grp_prop & c0)));
        assert_slice_excl_R7: assert (!(grp_gen && grp_prop));

        s  = p_bit ^ cy[W-1:0];
        gg = grp_gen;
        gp = grp_prop;
    end
endmodule

// File: rtl/cla2_lookahead.sv
module cla2_lookahead #(
    parameter int N = cla2_pkg::NUM_SLICES
) (
    input  logic [N-1:0] g_in,
    input  logic [N-1:0] p_in,
    input  logic         c0,
    output logic [N-1:0] c_slice,
    output logic         c_top,
    output logic         all_g,
    output logic         all_p
);
    logic [N:0] cy;
    logic       acc;
    logic       term;
    logic       tot_g;
    logic       tot_p;

    always_comb begin
        cy    = '0;
        cy[0] = c0;
        for (int k = 1; k <= N; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = g_in[j];
                for (int m = j + 1; m < k; m++) term = term & p_in[m];
                acc = acc | term;
            end
            term = c0;
            for (int m = 0; m < k; m++) term = term & p_in[m];
            cy[k] = acc | term;
        end
        tot_g = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = g_in[j];
            for (int m = j + 1; m < N; m++) term = term & p_in[m];
            tot_g = tot_g | term;
        end
        tot_p = &p_in;

        for (int k = 0; k < N; k++) begin
            assert_group_step_R6: assert (cy[k+1] == (g_in[k] | (p_in[k] & cy[k])));
        end
        assert_cout_form_R5: assert (cy[N] == (tot_g | (tot_p & c0)));

        c_slice = cy[N-1:0];
        c_top   = cy[N];
        all_g   = tot_g;
        all_p   = tot_p;
    end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
    import cla2_pkg::*;
#(
    parameter int SW = SLICE_W,
    parameter int NS = NUM_SLICES
) (
    input  logic [SW*NS-1:0] a_in,
    input  logic [SW*NS-1:0] b_in,
    input  logic             c_in,
    output logic [SW*NS-1:0] sum_out,
    output logic             c_out,
    output logic             grp_p,
    output logic             grp_g
);
    localparam int TOTAL_W = SW * NS;

    logic [NS-1:0] sl_g;
    logic [NS-1:0] sl_p;
    logic [NS-1:0] sl_cin;

    cla2_lookahead #(.N(NS)) u_lookahead (
        .g_in    (sl_g),
        .p_in    (sl_p),
        .c0      (c_in),
        .c_slice (sl_cin),
        .c_top   (c_out),
        .all_g   (grp_g),
        .all_p   (grp_p)
    );

    for (genvar k = 0; k < NS; k++) begin : g_slice
        cla2_slice #(.W(SW)) u_slice (
            .a  (a_in[k*SW +: SW]),
            .b  (b_in[k*SW +: SW]),
            .c0 (sl_cin[k]),
            .s  (sum_out[k*SW +: SW]),
            .gg (sl_g[k]),
            .gp (sl_p[k])
        );
    end

    if (TOTAL_W < 2) begin : g_width_guard
        initial $error("width too small");
    end
endmodule

// File: tb/cla2_adder_bench.sv
module cla2_adder_bench;
    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        ci;
        logic [16:0] total;
        logic        ep;
        logic        eg;
        logic [3:0]  bnd;
        bit          chain;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        c_in = 1'b0;
    logic [15:0] sum_out;
    logic        c_out;
    logic        grp_p;
    logic        grp_g;

    int    checks = 0;
    int    errors = 0;
    item_t q[$];

    always #4 clk = ~clk;

    cla2_adder u_cla2_adder (
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sum_out(sum_out), .c_out(c_out), .grp_p(grp_p), .grp_g(grp_g)
    );

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] x, input logic [15:0] y, input logic ci, input bit chain);
        item_t it;
        logic [16:0] part;
        @(negedge clk);
        a_in = x; b_in = y; c_in = ci;
        it.a = x; it.b = y; it.ci = ci; it.chain = chain;
        it.total = {1'b0, x} + {1'b0, y} + {16'b0, ci};
        it.ep = ((x ^ y) == 16'hFFFF);
        part = {1'b0, x} + {1'b0, y};
        it.eg = part[16];
        it.bnd = '0;
        for (int k = 1; k < 4; k++) begin
            part = {1'b0, x & ((17'h1 << (4*k)) - 1)} + {1'b0, y & ((17'h1 << (4*k)) - 1)} + {16'b0, ci};
            it.bnd[k] = part[4*k];
        end
        q.push_back(it);
    endtask

    // monitor: one expected item per rising edge
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            logic cb;
            it = q.pop_front();
            chk("R1 sum", {c_out, sum_out}, it.total);
            if (it.chain) chk("R2 chain", {c_out, sum_out}, 17'h10000);
            chk("R3 grp_p", {16'b0, grp_p}, {16'b0, it.ep});
            chk("R4 grp_g", {16'b0, grp_g}, {16'b0, it.eg});
            chk("R5 cout form", {16'b0, c_out}, {16'b0, grp_g | (grp_p & it.ci)});
            for (int k = 1; k < 4; k++) begin
                cb = sum_out[4*k] ^ it.a[4*k] ^ it.b[4*k];
                chk("R6 slice carry", {16'b0, cb}, {16'b0, it.bnd[k]});
            end
            chk("R7 exclusive", {16'b0, grp_g & grp_p}, 17'h0);
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, 1'b0);       // idle state, R1
        drive(16'hFFFF, 16'h0000, 1'b1, 1'b1);       // R2 full chain
        drive(16'hFFFF, 16'h0000, 1'b0, 1'b0);       // R3 propagate, no carry
        drive(16'h5555, 16'hAAAA, 1'b1, 1'b0);       // R3 independent of c_in
        drive(16'h1234, 16'hEDCB, 1'b0, 1'b0);
        drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b0);       // R4 generate
        drive(16'h8000, 16'h8000, 1'b0, 1'b0);       // R4 top-bit generate
        drive(16'h0FFF, 16'h0001, 1'b0, 1'b0);       // R6 stop at slice 3
        drive(16'h000F, 16'h0000, 1'b1, 1'b0);       // R6 into slice 1
        drive(16'h00F0, 16'h0010, 1'b0, 1'b0);       // R6 into slice 2
        drive(16'h7FFF, 16'h0000, 1'b1, 1'b0);       // R6 through three slices
        for (int i = 0; i < 400; i++)
            drive(16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule